// File: doc/BRIEF.md
# Flash Copy-Back Sequencer with In-Buffer Correction

This block moves one flash page from a source row to a destination row without the page leaving the device. It loads the source page into the device page buffer and streams the whole buffer (data plus spare/parity area) out to an error-check path. It then waits for the decoder's list of error locations. For each error it reads the single faulty byte back, flips the reported bit and writes the byte into the buffer at the same column. When the decoder's final marker has arrived and every patch is written, it programs the buffer into the destination row.

A page whose error count is above the correction limit is never programmed. A move that has to cross channels or alter the data is handed back at once as a request for the external copy path. The result of every accepted start is reported on exactly one one-cycle status pulse.

Command, readout, check and error interfaces are valid/ready streams. A beat transfers on a cycle where both valid and ready are high. While valid is high and ready is low, the source holds its payload unchanged. The readout stream is relayed to the check stream, so back-pressure on the check side stalls the readout. Ready/busy and the status pulses are plain levels.

Top module: `cb_sequencer`

## Requirements
- R1: A move issues commands in the order CB_READ(source row), BUF_OUT, then zero or more BYTE_OUT/BYTE_IN pairs, then CB_PROG(destination row). The cmd_op encoding is 0 CB_READ, 1 BUF_OUT, 2 BYTE_OUT, 3 BYTE_IN, 4 CB_PROG.
- R2: After BUF_OUT, exactly PAGE_BYTES+SPARE_BYTES readout beats are relayed to the check stream with unchanged data. chk_last is high on the final beat only.
- R3: An error beat carries a byte column (err_byte) and a bit index (err_bit). A beat with err_empty=1 carries no error. err_last marks the final beat, and a zero-error page is one beat with err_empty=1 and err_last=1.
- R4: For each error the block issues BYTE_OUT at err_byte, takes one readout byte, and issues BYTE_IN at the same column with that byte's err_bit inverted.
- R5: CB_PROG is issued only after the final error beat and after all of its patches.
- R6: If the count of non-empty error beats exceeds MAX_ERR, the block accepts the remaining beats up to err_last, pulses uncorr, and issues no CB_PROG.
- R7: A start with ext_copy=1 issues no flash command and pulses fallback.
- R8: A zero-error page issues no BYTE_OUT or BYTE_IN, only CB_READ, BUF_OUT and CB_PROG.
- R9: Each accepted start ends in exactly one pulse of done, uncorr or fallback, and each pulse lasts one cycle. A start that arrives while a move is in progress is ignored.
- R10: While cmd_valid is high and cmd_ready is low, cmd_valid and all command fields hold.
- R11: After CB_READ and after CB_PROG, the block waits for rb_ready before it issues the next command or pulses done. The device drops rb_ready by the cycle after it accepts the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a move (taken only when idle) |
| ext_copy | input | 1 | Move crosses channels or modifies data |
| src_row | input | ROW_W | Source row address |
| dst_row | input | ROW_W | Destination row address |
| cmd_valid | output | 1 | Flash command valid |
| cmd_ready | input | 1 | Flash command accepted |
| cmd_op | output | 3 | Command code |
| cmd_row | output | ROW_W | Row address of command |
| cmd_col | output | COL_W | Column (byte) address |
| cmd_data | output | DATA_W | Byte for BYTE_IN |
| rb_ready | input | 1 | Device ready (1) / busy (0) |
| rd_valid | input | 1 | Readout byte valid |
| rd_ready | output | 1 | Readout byte taken |
| rd_data | input | DATA_W | Readout byte |
| chk_valid | output | 1 | Check-path byte valid |
| chk_ready | input | 1 | Check path accepts byte |
| chk_data | output | DATA_W | Check-path byte |
| chk_last | output | 1 | Final byte of page |
| err_valid | input | 1 | Error beat valid |
| err_ready | output | 1 | Error beat taken |
| err_byte | input | COL_W | Faulty byte column |
| err_bit | input | BIT_W | Faulty bit within byte |
| err_empty | input | 1 | Beat carries no error |
| err_last | input | 1 | Final error beat |
| done | output | 1 | Move completed pulse |
| uncorr | output | 1 | Page uncorrectable pulse |
| fallback | output | 1 | External copy requested pulse |

## Verification
On the final error beat, two events can land in the same cycle: the error count passes the limit, and the end-of-list marker arrives. The bench provokes this by sending one more error than MAX_ERR, with err_last on the surplus beat. It judges the result by a single uncorr pulse, no CB_PROG, and no done. A second overlap puts a fresh start on top of a running readout. The bench expects the move to finish normally, with a single CB_READ and no fallback pulse.

// File: rtl/cb_pkg.sv
package cb_pkg;
  typedef enum logic [2:0] {
    OP_CB_READ  = 3'd0,
    OP_BUF_OUT  = 3'd1,
    OP_BYTE_OUT = 3'd2,
    OP_BYTE_IN  = 3'd3,
    OP_CB_PROG  = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CMD, S_RD_WAIT, S_OUT_CMD, S_STREAM, S_ERR,
    S_FETCH_CMD, S_FETCH_DATA, S_PATCH_CMD, S_PROG_CMD, S_PROG_WAIT
  } st_e;
endpackage

// File: rtl/cb_beat_counter.sv
module cb_beat_counter #(
  parameter int TOTAL = 8832
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic last
);
  localparam int CW = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(TOTAL - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clr)                cnt_q <= '0;
    else if (step && last)       cnt_q <= '0;
    else if (step)               cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/cb_err_tracker.sv
module cb_err_tracker #(
  parameter int MAX_ERR = 500,
  parameter int COL_W   = 14,
  parameter int BIT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             empty,
  input  logic             last_in,
  input  logic [COL_W-1:0] byte_in,
  input  logic [BIT_W-1:0] bit_in,
  output logic [COL_W-1:0] loc_col,
  output logic [BIT_W-1:0] loc_bit,
  output logic             over_now,
  output logic             over_q,
  output logic             final_q
);
  localparam int CNT_W = $clog2(MAX_ERR + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ERR);

  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit      = take && !empty;
  assign over_now = over_q || (hit && (cnt_q == LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      over_q  <= 1'b0;
      final_q <= 1'b0;
      loc_col <= '0;
      loc_bit <= '0;
    end else if (clr) begin
      cnt_q   <= '0;
      over_q  <= 1'b0;
      final_q <= 1'b0;
    end else if (take) begin
      final_q <= last_in;
      if (hit) begin
        if (over_now) begin
          over_q <= 1'b1;
        end else begin
          cnt_q   <= cnt_q + 1'b1;
          loc_col <= byte_in;
          loc_bit <= bit_in;
        end
      end
    end
  end

  // R6: the limit flag is only ever raised once the count has reached the limit
  assert_over_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    over_q |-> (cnt_q == LIMIT));
endmodule

// File: rtl/cb_bit_flip.sv
module cb_bit_flip #(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic [DATA_W-1:0] din,
  input  logic [BIT_W-1:0]  sel,
  output logic [DATA_W-1:0] dout
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [BIT_W-1:0] IDX = BIT_W'(i);
    assign dout[i] = din[i] ^ (sel == IDX);
  end
endmodule

// File: rtl/cb_sequencer.sv
module cb_sequencer
  import cb_pkg::*;
#(
  parameter int PAGE_BYTES  = 8192,
  parameter int SPARE_BYTES = 640,
  parameter int MAX_ERR     = 500,
  parameter int ROW_W       = 24,
  parameter int DATA_W      = 8,
  localparam int TOTAL      = PAGE_BYTES + SPARE_BYTES,
  localparam int COL_W      = $clog2(TOTAL),
  localparam int BIT_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ext_copy,
  input  logic [ROW_W-1:0]  src_row,
  input  logic [ROW_W-1:0]  dst_row,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              rb_ready,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              chk_valid,
  input  logic              chk_ready,
  output logic [DATA_W-1:0] chk_data,
  output logic              chk_last,
  input  logic              err_valid,
  output logic              err_ready,
  input  logic [COL_W-1:0]  err_byte,
  input  logic [BIT_W-1:0]  err_bit,
  input  logic              err_empty,
  input  logic              err_last,
  output logic              done,
  output logic              uncorr,
  output logic              fallback
);
  st_e               state_q;
  logic [ROW_W-1:0]  src_q, dst_q;
  logic [DATA_W-1:0] orig_q, patched;
  logic              beat_last, begin_move, cmd_fire, rd_fire, err_fire, stream_step;
  logic [COL_W-1:0]  loc_col;
  logic [BIT_W-1:0]  loc_bit;
  logic              over_now, over_q, final_q;
  logic              done_q, uncorr_q, fb_q;
  op_e               op;

  assign begin_move  = (state_q == S_IDLE) && start && !ext_copy;
  assign cmd_fire    = cmd_valid && cmd_ready;
  assign rd_fire     = rd_valid && rd_ready;
  assign err_fire    = err_valid && err_ready;
  assign stream_step = (state_q == S_STREAM) && rd_valid && chk_ready;

  cb_beat_counter #(.TOTAL(TOTAL)) u_beats (
    .clk(clk), .rst_n(rst_n), .clr(begin_move), .step(stream_step), .last(beat_last)
  );

  cb_err_tracker #(.MAX_ERR(MAX_ERR), .COL_W(COL_W), .BIT_W(BIT_W)) u_errs (
    .clk(clk), .rst_n(rst_n), .clr(begin_move), .take(err_fire),
    .empty(err_empty), .last_in(err_last), .byte_in(err_byte), .bit_in(err_bit),
    .loc_col(loc_col), .loc_bit(loc_bit), .over_now(over_now),
    .over_q(over_q), .final_q(final_q)
  );

  cb_bit_flip #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_flip (
    .din(orig_q), .sel(loc_bit), .dout(patched)
  );

  // stream relay and handshakes
  assign chk_valid = (state_q == S_STREAM) && rd_valid;
  assign chk_data  = rd_data;
  assign chk_last  = chk_valid && beat_last;
  assign rd_ready  = ((state_q == S_STREAM) && chk_ready) || (state_q == S_FETCH_DATA);
  assign err_ready = (state_q == S_ERR);

  // command mux
  always_comb begin
    cmd_valid = 1'b0;
    op        = OP_CB_READ;
    cmd_row   = src_q;
    cmd_col   = '0;
    cmd_data  = '0;
    unique case (state_q)
      S_RD_CMD:    begin cmd_valid = 1'b1; op = OP_CB_READ; end
      S_OUT_CMD:   begin cmd_valid = 1'b1; op = OP_BUF_OUT; end
      S_FETCH_CMD: begin cmd_valid = 1'b1; op = OP_BYTE_OUT; cmd_col = loc_col; end
      S_PATCH_CMD: begin
        cmd_valid = 1'b1; op = OP_BYTE_IN; cmd_col = loc_col; cmd_data = patched;
      end
      S_PROG_CMD:  begin cmd_valid = 1'b1; op = OP_CB_PROG; cmd_row = dst_q; end
      default: ;
    endcase
  end
  assign cmd_op = op;

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      orig_q   <= '0;
      done_q   <= 1'b0;
      uncorr_q <= 1'b0;
      fb_q     <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      uncorr_q <= 1'b0;
      fb_q     <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start) begin
          if (ext_copy) fb_q <= 1'b1;
          else begin
            src_q   <= src_row;
            dst_q   <= dst_row;
            state_q <= S_RD_CMD;
          end
        end
        S_RD_CMD:     if (cmd_fire) state_q <= S_RD_WAIT;
        S_RD_WAIT:    if (rb_ready) state_q <= S_OUT_CMD;
        S_OUT_CMD:    if (cmd_fire) state_q <= S_STREAM;
        S_STREAM:     if (stream_step && beat_last) state_q <= S_ERR;
        S_ERR: if (err_fire) begin
          if (over_now) begin
            if (err_last) begin
              uncorr_q <= 1'b1;
              state_q  <= S_IDLE;
            end
          end else if (!err_empty) state_q <= S_FETCH_CMD;
          else if (err_last)       state_q <= S_PROG_CMD;
        end
        S_FETCH_CMD:  if (cmd_fire) state_q <= S_FETCH_DATA;
        S_FETCH_DATA: if (rd_fire) begin
          orig_q  <= rd_data;
          state_q <= S_PATCH_CMD;
        end
        S_PATCH_CMD:  if (cmd_fire) state_q <= final_q ? S_PROG_CMD : S_ERR;
        S_PROG_CMD:   if (cmd_fire) state_q <= S_PROG_WAIT;
        S_PROG_WAIT:  if (rb_ready) begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign uncorr   = uncorr_q;
  assign fallback = fb_q;

  // R10: a stalled command holds its payload
  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable({cmd_op, cmd_row, cmd_col, cmd_data})));

  // R9: status pulses last one cycle and never coincide
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_one_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, uncorr, fallback}) <= 1);

  // R6: an over-limit page is never programmed
  assert_no_prog_over_R6: assert property (@(posedge clk) disable iff (!rst_n)
    over_q |-> !(cmd_valid && (cmd_op == OP_CB_PROG)));

  // R4: a patch differs from the fetched byte in exactly one bit
  assert_single_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_BYTE_IN)) |-> ($countones(cmd_data ^ orig_q) == 1));

  // R11: buffer readout is only requested when the device is ready
  assert_ready_before_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid && (cmd_op == OP_BUF_OUT)) |-> $past(rb_ready));
endmodule

// File: tb/tb_cb_sequencer.sv
module tb_cb_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE = 64;
  localparam int SPARE = 8;
  localparam int MAXE = 3;
  localparam int ROWW = 16;
  localparam int TOT = PAGE + SPARE;
  localparam int CW = $clog2(TOT);

  typedef struct packed {
    logic             ext;
    logic [2:0]       n;
    logic [3:0][6:0]  pos;
    logic [3:0][2:0]  bits;
    logic [1:0]       res;   // 0 done, 1 uncorr, 2 fallback
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{ext:1'b0, n:3'd0, pos:{7'd0,7'd0,7'd0,7'd0},     bits:{3'd0,3'd0,3'd0,3'd0}, res:2'd0},
    '{ext:1'b0, n:3'd1, pos:{7'd0,7'd0,7'd0,7'd0},     bits:{3'd0,3'd0,3'd0,3'd0}, res:2'd0},
    '{ext:1'b0, n:3'd2, pos:{7'd0,7'd0,7'd10,7'd71},   bits:{3'd0,3'd0,3'd3,3'd7}, res:2'd0},
    '{ext:1'b0, n:3'd3, pos:{7'd0,7'd33,7'd5,7'd64},   bits:{3'd0,3'd2,3'd6,3'd1}, res:2'd0},
    '{ext:1'b0, n:3'd4, pos:{7'd5,7'd4,7'd3,7'd2},     bits:{3'd3,3'd2,3'd1,3'd0}, res:2'd1},
    '{ext:1'b1, n:3'd0, pos:{7'd0,7'd0,7'd0,7'd0},     bits:{3'd0,3'd0,3'd0,3'd0}, res:2'd2}
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, ext_copy = 0;
  logic [ROWW-1:0] src_row = '0, dst_row = '0;
  logic cmd_valid, cmd_ready = 0;
  logic [2:0] cmd_op;
  logic [ROWW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;
  logic [7:0] cmd_data;
  logic rb_ready = 1;
  logic rd_valid = 0, rd_ready;
  logic [7:0] rd_data = '0;
  logic chk_valid, chk_ready = 0, chk_last;
  logic [7:0] chk_data;
  logic err_valid = 0, err_ready, err_empty = 0, err_last = 0;
  logic [CW-1:0] err_byte = '0;
  logic [2:0] err_bit = '0;
  logic done, uncorr, fallback;

  cb_sequencer #(.PAGE_BYTES(PAGE), .SPARE_BYTES(SPARE), .MAX_ERR(MAXE),
                 .ROW_W(ROWW), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_copy(ext_copy),
    .src_row(src_row), .dst_row(dst_row),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_data(cmd_data), .rb_ready(rb_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .chk_valid(chk_valid), .chk_ready(chk_ready), .chk_data(chk_data), .chk_last(chk_last),
    .err_valid(err_valid), .err_ready(err_ready), .err_byte(err_byte), .err_bit(err_bit),
    .err_empty(err_empty), .err_last(err_last),
    .done(done), .uncorr(uncorr), .fallback(fallback)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, fails = 0;
  // flash model state
  logic [7:0] img [TOT];
  logic [7:0] pgbuf [TOT];
  logic [7:0] prog_img [TOT];
  int seq [64];
  int nseq = 0, nprog = 0, nbytein = 0, busy = 0, mode = 0, idx = 0;
  int chk_idx = 0, chk_bad = 0, last_bad = 0, rb_bad = 0;
  int ndone = 0, nunc = 0, nfb = 0, wide_pulse = 0, read_row = 0, prog_row = 0;
  int cyc = 0;

  function automatic logic [7:0] clean(int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // device model: samples at the falling edge, applies just after the rising edge
  initial begin
    bit hc, hr, hk, pd, pu, pf;
    logic [2:0] op; logic [ROWW-1:0] row; logic [CW-1:0] col; logic [7:0] dat;
    logic [7:0] kd; logic kl;
    pd = 0; pu = 0; pf = 0;
    forever begin
      @(negedge clk);
      hc = cmd_valid && cmd_ready; op = cmd_op; row = cmd_row; col = cmd_col; dat = cmd_data;
      hr = rd_valid && rd_ready;
      hk = chk_valid && chk_ready; kd = chk_data; kl = chk_last;
      if (done) begin ndone++; if (busy != 0) rb_bad++; end
      if (uncorr) nunc++;
      if (fallback) nfb++;
      if ((done && pd) || (uncorr && pu) || (fallback && pf)) wide_pulse++;
      pd = done; pu = uncorr; pf = fallback;
      if (hk) begin
        if (kd !== pgbuf[chk_idx]) chk_bad++;
        if (kl != (chk_idx == TOT - 1)) last_bad++;
        chk_idx++;
      end
      @(posedge clk); #1;
      cyc++;
      if (busy > 0) busy--;
      if (hr) begin
        if (mode == 1) begin idx++; if (idx == TOT) mode = 0; end
        else mode = 0;
      end
      if (hc) begin
        if (nseq < 64) seq[nseq] = int'(op);
        nseq++;
        case (op)
          3'd0: begin for (int i = 0; i < TOT; i++) pgbuf[i] = img[i]; busy = 3; read_row = int'(row); end
          3'd1: begin if (busy != 0) rb_bad++; mode = 1; idx = 0; chk_idx = 0; end
          3'd2: begin mode = 2; idx = int'(col); end
          3'd3: begin pgbuf[col] = dat; nbytein++; end
          3'd4: begin
            if (busy != 0) rb_bad++;
            for (int i = 0; i < TOT; i++) prog_img[i] = pgbuf[i];
            prog_row = int'(row); nprog++; busy = 3;
          end
          default: ;
        endcase
      end
      rb_ready  = (busy == 0);
      rd_valid  = (mode != 0);
      rd_data   = (mode != 0) ? pgbuf[idx] : 8'h00;
      cmd_ready = (cyc % 3) != 0;
      chk_ready = (cyc % 4) != 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic clear_log();
    nseq = 0; nbytein = 0; chk_bad = 0; last_bad = 0; rb_bad = 0; chk_idx = 0;
    for (int i = 0; i < TOT; i++) prog_img[i] = 8'hxx;
  endtask

  task automatic kick(input logic ext, input int s, input int d);
    @(posedge clk); #1;
    start = 1; ext_copy = ext; src_row = ROWW'(s); dst_row = ROWW'(d);
    @(posedge clk); #1;
    start = 0; ext_copy = 0;
  endtask

  task automatic send_err(input int b, input int bt, input logic emp, input logic lst);
    bit got;
    err_valid = 1; err_byte = CW'(b); err_bit = 3'(bt); err_empty = emp; err_last = lst;
    do begin
      @(negedge clk); got = err_ready;
      @(posedge clk); #1;
    end while (!got);
    err_valid = 0; err_empty = 0; err_last = 0;
  endtask

  task automatic wait_status();
    int base;
    base = ndone + nunc + nfb;
    while (ndone + nunc + nfb == base) @(negedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  function automatic int image_ok();
    int bad = 0;
    for (int i = 0; i < TOT; i++) if (prog_img[i] !== clean(i)) bad++;
    return bad;
  endfunction

  initial begin
    int d0, u0, f0, p0, exp_seq[64], ne;
    vec_t v;
    for (int i = 0; i < TOT; i++) img[i] = clean(i);
    repeat (3) @(posedge clk);
    #1;
    // reset state
    check(!cmd_valid && !err_ready && !rd_ready && !chk_valid, "R9 reset idle outputs",
          int'({cmd_valid, err_ready, rd_ready, chk_valid}), 0);
    check(!done && !uncorr && !fallback, "R9 reset status low",
          int'({done, uncorr, fallback}), 0);
    rst_n = 1;

    // table walk
    for (int t = 0; t < 6; t++) begin
      v = VECS[t];
      for (int i = 0; i < TOT; i++) img[i] = clean(i);
      for (int k = 0; k < int'(v.n); k++) img[v.pos[k]] = img[v.pos[k]] ^ (8'h01 << v.bits[k]);
      clear_log();
      d0 = ndone; u0 = nunc; f0 = nfb; p0 = nprog;
      kick(v.ext, 100 + t, 200 + t);
      if (!v.ext) begin
        if (v.n == 0) send_err(0, 0, 1'b1, 1'b1);
        else for (int k = 0; k < int'(v.n); k++)
          send_err(int'(v.pos[k]), int'(v.bits[k]), 1'b0, k == int'(v.n) - 1);
      end
      wait_status();
      case (v.res)
        2'd0: begin
          check(ndone == d0 + 1 && nunc == u0 && nfb == f0, $sformatf("R9 vec%0d done only", t), ndone - d0, 1);
          check(prog_row == 200 + t && read_row == 100 + t, $sformatf("R1 vec%0d rows", t), prog_row, 200 + t);
          ne = 0;
          exp_seq[ne++] = 0; exp_seq[ne++] = 1;
          for (int k = 0; k < int'(v.n); k++) begin exp_seq[ne++] = 2; exp_seq[ne++] = 3; end
          exp_seq[ne++] = 4;
          begin
            int mism = (nseq != ne) ? 1 : 0;
            for (int k = 0; k < ne && k < nseq; k++) if (seq[k] != exp_seq[k]) mism++;
            check(mism == 0, $sformatf("R1 R5 vec%0d command order", t), nseq, ne);
          end
          check(image_ok() == 0, $sformatf("R4 vec%0d programmed image corrected", t), image_ok(), 0);
          check(nbytein == int'(v.n), $sformatf("R8 vec%0d patch count", t), nbytein, int'(v.n));
          check(chk_idx == TOT && chk_bad == 0 && last_bad == 0,
                $sformatf("R2 vec%0d check stream", t), chk_idx, TOT);
          check(rb_bad == 0, $sformatf("R11 vec%0d waits on ready", t), rb_bad, 0);
        end
        2'd1: begin
          check(nunc == u0 + 1 && ndone == d0, $sformatf("R6 vec%0d uncorr pulse", t), nunc - u0, 1);
          check(nprog == p0, $sformatf("R6 vec%0d no program", t), nprog - p0, 0);
        end
        default: begin
          check(nfb == f0 + 1 && ndone == d0, $sformatf("R7 vec%0d fallback pulse", t), nfb - f0, 1);
          check(nseq == 0, $sformatf("R7 vec%0d no commands", t), nseq, 0);
        end
      endcase
    end

    // R3: empty beats carry no error, only one patch results
    for (int i = 0; i < TOT; i++) img[i] = clean(i);
    img[20] = img[20] ^ 8'h20;
    clear_log(); d0 = ndone;
    kick(1'b0, 7, 8);
    send_err(0, 0, 1'b1, 1'b0);
    send_err(20, 5, 1'b0, 1'b0);
    send_err(0, 0, 1'b1, 1'b1);
    wait_status();
    check(ndone == d0 + 1 && nbytein == 1, "R3 empty beats skipped", nbytein, 1);
    check(image_ok() == 0, "R3 image after empty beats", image_ok(), 0);

    // R9: start during a running move is ignored
    for (int i = 0; i < TOT; i++) img[i] = clean(i);
    clear_log(); d0 = ndone; f0 = nfb;
    kick(1'b0, 9, 10);
    repeat (20) @(posedge clk);
    kick(1'b1, 11, 12);
    send_err(0, 0, 1'b1, 1'b1);
    wait_status();
    check(ndone == d0 + 1 && nfb == f0, "R9 busy start ignored", nfb - f0, 0);
    check(nseq == 3 && prog_row == 10, "R9 single move", nseq, 3);

    check(wide_pulse == 0, "R9 one-cycle pulses", wide_pulse, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule